// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves control-flow instructions for a 64-bit register machine whose program counter counts 64-bit instruction slots. Each cycle it takes an 8-bit opcode, the destination and source register values, a 32-bit immediate, a signed 16-bit displacement and the current program counter. It decides whether the branch is taken and computes the next program counter. It also raises flags for call and return instructions, which it recognises but does not carry out, and for encodings it cannot accept. All outputs are registered, so they appear one clock after the inputs are presented.

The low three opcode bits select the operand width. Class 5 compares full 64-bit values. Class 6 runs the same compares on the low 32 bits only. Opcode bit 3 picks the second operand: the immediate, or the source register. The upper nibble holds the condition. The conditions are equality, inequality, a bit-test, and both unsigned and signed orderings, plus an unconditional jump. Fetch, call execution and return-value handling are done by neighbouring blocks.

Top module: `br_unit`

## Requirements
- R1: While reset is low at a rising edge, every output goes to zero in the following cycle (taken, call, exit and illegal flags low, next program counter 0).
- R2: Only opcodes whose bits [2:0] equal 5 (64-bit compare) or 6 (32-bit compare on the low halves) are branch instructions; any other class gives not-taken, all flags low and next counter = counter + 1.
- R3: Opcode bit 3 = 1 compares against the source register and bit 3 = 0 against the immediate. In the 64-bit class the immediate is sign-extended from bit 31; in the 32-bit class it is used as is.
- R4: Condition 0x1 is taken when the operands are equal, and condition 0x5 when they differ.
- R5: Unsigned orderings are taken for 0x2 greater-than, 0x3 greater-or-equal, 0xa less-than and 0xb less-or-equal.
- R6: Signed orderings are taken for 0x6 greater-than, 0x7 greater-or-equal, 0xc less-than and 0xd less-or-equal, with the sign taken from bit 63 in the 64-bit class and from bit 31 in the 32-bit class.
- R7: Condition 0x4 (bit-test) is taken when the AND of the two operands at the class width is nonzero.
- R8: Condition 0x0 in the 64-bit class is always taken.
- R9: The next program counter is counter + 1 when the branch is not taken, and counter + 1 + the sign-extended displacement when it is taken, wrapping modulo 2^32.
- R10: Condition 0x8 raises the call flag in either class and condition 0x9 raises the exit flag in the 64-bit class. Both leave the branch not taken.
- R11: Conditions 0xe and 0xf in either class, and conditions 0x0 and 0x9 in the 32-bit class, raise the illegal flag, force not-taken and keep the call and exit flags low.
- R12: The outputs in each cycle reflect the inputs sampled at the preceding rising edge, with no dependence on earlier instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 8 | Opcode: condition [7:4], operand select [3], class [2:0] |
| dst_i | input | 64 | Destination register value (first operand) |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate operand |
| off_i | input | 16 | Signed branch displacement in instruction slots |
| pc_i | input | 32 | Current program counter |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next program counter |
| call_o | output | 1 | Call instruction recognised |
| exit_o | output | 1 | Exit instruction recognised |
| illegal_o | output | 1 | Unsupported branch encoding |

## Verification
The operand patterns are chosen so that each one separates two candidate behaviours. A value with only bit 63 set, compared against 1, gives different results for the signed and unsigned orderings. Values that differ only in the upper 32 bits separate the two classes. An all-ones immediate compared against a zero-extended all-ones register value shows whether the immediate was sign-extended. Equal operands sit on the boundary between the strict and non-strict orderings. Random opcodes and operands, with equality forced in a share of them, are then checked on every instruction against a behavioural model, together with counter wrap at both ends and negative displacements.

// File: rtl/br_pkg.sv
// Shared definitions for the branch unit: condition codes, class values
// and the decoded-instruction record passed between the submodules.
package br_pkg;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'h0,
        CC_EQ     = 4'h1,
        CC_UGT    = 4'h2,
        CC_UGE    = 4'h3,
        CC_BITS   = 4'h4,
        CC_NE     = 4'h5,
        CC_SGT    = 4'h6,
        CC_SGE    = 4'h7,
        CC_CALL   = 4'h8,
        CC_EXIT   = 4'h9,
        CC_ULT    = 4'ha,
        CC_ULE    = 4'hb,
        CC_SLT    = 4'hc,
        CC_SLE    = 4'hd,
        CC_RSV_E  = 4'he,
        CC_RSV_F  = 4'hf
    } cond_e;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef struct packed {
        logic  is_jump;
        logic  narrow;
        logic  use_reg;
        cond_e cond;
        logic  illegal;
        logic  call;
        logic  exit_op;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
// Opcode decoder. Splits the opcode into class, operand select and
// condition, and flags call, exit and illegal encodings.
// Assumes: opcode layout cond[7:4], use_reg[3], class[2:0].
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] op_i,
    output dec_t       dec_o
);

    logic  is_wide;
    logic  is_narrow;
    cond_e cond;

    // Class and condition fields.
    always_comb begin
        is_wide   = (op_i[2:0] == CLS_WIDE);
        is_narrow = (op_i[2:0] == CLS_NARROW);
        cond      = cond_e'(op_i[7:4]);
    end

    // Build the decoded record, including legality per class.
    always_comb begin
        dec_o.is_jump = is_wide || is_narrow;
        dec_o.narrow  = is_narrow;
        dec_o.use_reg = op_i[3];
        dec_o.cond    = cond;
        dec_o.illegal = (is_wide || is_narrow) &&
                        ((cond == CC_RSV_E) || (cond == CC_RSV_F) ||
                         (is_narrow && ((cond == CC_ALWAYS) || (cond == CC_EXIT))));
        dec_o.call    = (is_wide || is_narrow) && (cond == CC_CALL);
        dec_o.exit_op = is_wide && (cond == CC_EXIT);
    end

endmodule

// File: rtl/br_compare.sv
// Condition evaluator. Forms the second operand (register or immediate),
// compares at both widths in parallel lanes and picks the lane by class.
// Assumes: IMM_W <= HALF_W so the narrow lane sees the immediate unchanged.
module br_compare
    import br_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  dec_t              dec_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              taken_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int N_LANE = 2;

    logic [DATA_W-1:0] opb;
    logic [N_LANE-1:0] lane_eq;
    logic [N_LANE-1:0] lane_ult;
    logic [N_LANE-1:0] lane_slt;
    logic [N_LANE-1:0] lane_nz;
    logic              eq, ult, slt, nz;
    logic              cond_true;

    // Second operand: source register or sign-extended immediate.
    always_comb begin
        opb = dec_i.use_reg ? src_i
                            : {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end

    // Lane 0 compares the full width, lane 1 the low half.
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int W = (g == 0) ? DATA_W : HALF_W;
        logic [W-1:0] a_l;
        logic [W-1:0] b_l;

        // Per-lane relations on the truncated operands.
        always_comb begin
            a_l         = dst_i[W-1:0];
            b_l         = opb[W-1:0];
            lane_eq[g]  = (a_l == b_l);
            lane_ult[g] = (a_l < b_l);
            lane_slt[g] = ($signed(a_l) < $signed(b_l));
            lane_nz[g]  = |(a_l & b_l);
        end
    end

    // Lane choice by class.
    always_comb begin
        eq  = dec_i.narrow ? lane_eq[1]  : lane_eq[0];
        ult = dec_i.narrow ? lane_ult[1] : lane_ult[0];
        slt = dec_i.narrow ? lane_slt[1] : lane_slt[0];
        nz  = dec_i.narrow ? lane_nz[1]  : lane_nz[0];
    end

    // Condition table.
    always_comb begin
        unique case (dec_i.cond)
            CC_ALWAYS: cond_true = 1'b1;
            CC_EQ:     cond_true = eq;
            CC_NE:     cond_true = !eq;
            CC_UGT:    cond_true = !ult && !eq;
            CC_UGE:    cond_true = !ult;
            CC_ULT:    cond_true = ult;
            CC_ULE:    cond_true = ult || eq;
            CC_SGT:    cond_true = !slt && !eq;
            CC_SGE:    cond_true = !slt;
            CC_SLT:    cond_true = slt;
            CC_SLE:    cond_true = slt || eq;
            CC_BITS:   cond_true = nz;
            default:   cond_true = 1'b0;
        endcase
    end

    // Only legal branch instructions may be taken.
    always_comb begin
        taken_o = dec_i.is_jump && !dec_i.illegal && cond_true;
    end

endmodule

// File: rtl/br_target.sv
// Next program counter: one slot ahead, plus the sign-extended
// displacement when the branch is taken. Wraps modulo 2^PC_W.
// Assumes: OFF_W <= PC_W.
module br_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             taken_i,
    output logic [PC_W-1:0]  next_pc_o
);

    logic [PC_W-1:0] disp;

    // Displacement applied only when taken.
    always_comb begin
        disp      = taken_i ? {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i} : '0;
        next_pc_o = pc_i + PC_W'(1) + disp;
    end

endmodule

// File: rtl/br_unit.sv
// Branch condition and target unit, top level. Decodes the opcode,
// evaluates the condition, computes the next counter and registers all
// results. Assumes a synchronous active-low reset.
module br_unit #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              call_o,
    output logic              exit_o,
    output logic              illegal_o
);

    br_pkg::dec_t    dec;
    logic            taken_c;
    logic [PC_W-1:0] next_pc_c;

    br_decode i_decode (
        .op_i  (op_i),
        .dec_o (dec)
    );

    br_compare #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) i_compare (
        .dec_i   (dec),
        .dst_i   (dst_i),
        .src_i   (src_i),
        .imm_i   (imm_i),
        .taken_o (taken_c)
    );

    br_target #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) i_target (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .taken_i   (taken_c),
        .next_pc_o (next_pc_c)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            call_o    <= 1'b0;
            exit_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            taken_o   <= taken_c;
            next_pc_o <= next_pc_c;
            call_o    <= dec.call;
            exit_o    <= dec.exit_op;
            illegal_o <= dec.illegal;
        end
    end

endmodule

// File: rtl/br_unit_chk.sv
// Property checker for br_unit, attached by bind. Observes ports only.
module br_unit_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      op_i,
    input logic [PC_W-1:0] pc_i,
    input logic            taken_o,
    input logic [PC_W-1:0] next_pc_o,
    input logic            call_o,
    input logic            exit_o,
    input logic            illegal_o
);

    logic primed   = 1'b0;
    logic rst_prev = 1'b0;

    // Marks cycles whose outputs come from inputs sampled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // Remembers that the previous edge saw reset low.
    always_ff @(posedge clk) begin
        rst_prev <= !rst_n;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst_prev |-> (!taken_o && !call_o && !exit_o && !illegal_o && next_pc_o == '0));

    assert_taken_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && taken_o) |-> ($past(op_i[2:0]) == 3'd5 || $past(op_i[2:0]) == 3'd6));

    assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_W'(1)));

    assert_call_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o || exit_o) |-> (!taken_o && !(call_o && exit_o)));

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!taken_o && !call_o && !exit_o));

    assert_always_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_i) == 8'h05) |-> taken_o);

endmodule

bind br_unit br_unit_chk #(.PC_W(PC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .pc_i      (pc_i),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o),
    .call_o    (call_o),
    .exit_o    (exit_o),
    .illegal_o (illegal_o)
);

// File: tb/test_br_unit.sv
// Self-checking bench for br_unit with a behavioural reference model.
module test_br_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_i = '0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [31:0] imm_i = '0;
    logic [15:0] off_i = '0;
    logic [31:0] pc_i = '0;
    logic        taken_o;
    logic [31:0] next_pc_o;
    logic        call_o;
    logic        exit_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    br_unit i_br_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .dst_i     (dst_i),
        .src_i     (src_i),
        .imm_i     (imm_i),
        .off_i     (off_i),
        .pc_i      (pc_i),
        .taken_o   (taken_o),
        .next_pc_o (next_pc_o),
        .call_o    (call_o),
        .exit_o    (exit_o),
        .illegal_o (illegal_o)
    );

    // Behavioural model written from the requirements.
    task automatic ref_model(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                             input logic [31:0] im, input logic [15:0] of, input logic [31:0] pc,
                             output logic tk, output logic [31:0] np,
                             output logic cl, output logic ex, output logic il);
        int          cls;
        int          code;
        bit          narrow;
        logic [63:0] a, b;
        longint      sa, sb;
        cls = int'(op[2:0]);
        code = int'(op[7:4]);
        narrow = (cls == 6);
        tk = 0; cl = 0; ex = 0; il = 0;
        if (cls == 5 || cls == 6) begin
            b = op[3] ? s : {{32{im[31]}}, im};
            if (narrow) begin
                a  = {32'h0, d[31:0]};
                sa = longint'($signed(d[31:0]));
                sb = longint'($signed(b[31:0]));
                b  = {32'h0, b[31:0]};
            end else begin
                a  = d;
                sa = $signed(d);
                sb = $signed(b);
            end
            case (code)
                0:  if (narrow) il = 1; else tk = 1;
                1:  tk = (a == b);
                2:  tk = (a > b);
                3:  tk = (a >= b);
                4:  tk = ((a & b) != 64'h0);
                5:  tk = (a != b);
                6:  tk = (sa > sb);
                7:  tk = (sa >= sb);
                8:  cl = 1;
                9:  if (narrow) il = 1; else ex = 1;
                10: tk = (a < b);
                11: tk = (a <= b);
                12: tk = (sa < sb);
                13: tk = (sa <= sb);
                default: il = 1;
            endcase
        end
        np = pc + 32'd1 + (tk ? {{16{of[15]}}, of} : 32'h0);
    endtask

    // Compare all outputs with the expected set.
    task automatic compare(input string tag, input logic tk, input logic [31:0] np,
                           input logic cl, input logic ex, input logic il);
        n_checks++;
        if (taken_o !== tk || next_pc_o !== np || call_o !== cl || exit_o !== ex || illegal_o !== il) begin
            n_fail++;
            $display("FAIL %s: got taken=%b pc=%h call=%b exit=%b ill=%b, expected taken=%b pc=%h call=%b exit=%b ill=%b",
                     tag, taken_o, next_pc_o, call_o, exit_o, illegal_o, tk, np, cl, ex, il);
        end
    endtask

    // Present one instruction, let it pass the register, check results.
    task automatic apply(input string tag, input logic [7:0] op, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im, input logic [15:0] of,
                         input logic [31:0] pc);
        logic tk, cl, ex, il;
        logic [31:0] np;
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; imm_i = im; off_i = of; pc_i = pc;
        ref_model(op, d, s, im, of, pc, tk, np, cl, ex, il);
        @(negedge clk);
        compare(tag, tk, np, cl, ex, il);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        op_i = 8'h05; pc_i = 32'h10;
        repeat (3) @(negedge clk);
        compare("R1 reset", 0, 32'h0, 0, 0, 0);
        rst_n = 1'b1;

        // R2: non-branch classes
        apply("R2 alu class", 8'h1c, 64'h5, 64'h5, 32'h0, 16'h0007, 32'd100);
        apply("R2 store class", 8'h03, 64'h0, 64'h0, 32'h0, 16'h0007, 32'd100);
        // R8: unconditional, negative displacement
        apply("R8 always wide", 8'h05, 64'h0, 64'h0, 32'h0, 16'hfffb, 32'd100);
        // R4
        apply("R4 eq reg", 8'h1d, 64'h1234, 64'h1234, 32'h9, 16'h0007, 32'd200);
        apply("R4 ne equal", 8'h5d, 64'h1234, 64'h1234, 32'h9, 16'h0007, 32'd200);
        apply("R4 ne upper", 8'h5d, 64'h1_0000_1234, 64'h1234, 32'h0, 16'h0007, 32'd200);
        apply("R4 ne narrow", 8'h5e, 64'h1_0000_1234, 64'h1234, 32'h0, 16'h0007, 32'd200);
        // R3: operand select and immediate extension
        apply("R3 imm not reg", 8'h15, 64'h1234, 64'h1234, 32'h9, 16'h0007, 32'd300);
        apply("R3 imm sext wide", 8'h15, 64'hffff_ffff_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0003, 32'd300);
        apply("R3 imm zext miss", 8'h15, 64'h0000_0000_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0003, 32'd300);
        apply("R3 imm narrow", 8'h16, 64'h1234_5678_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0003, 32'd300);
        // R5 and R6
        apply("R5 ugt msb", 8'h2d, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 16'h0010, 32'd400);
        apply("R6 sgt msb", 8'h6d, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 16'h0010, 32'd400);
        apply("R6 sgt narrow bit31", 8'h6e, 64'h0000_0001_8000_0000, 64'h1, 32'h0, 16'h0010, 32'd400);
        apply("R6 sgt wide bit31", 8'h6d, 64'h0000_0001_8000_0000, 64'h1, 32'h0, 16'h0010, 32'd400);
        apply("R5 ugt narrow upper", 8'h2e, 64'hffff_ffff_0000_0001, 64'h2, 32'h0, 16'h0010, 32'd400);
        apply("R5 uge equal", 8'h3d, 64'h77, 64'h77, 32'h0, 16'h0010, 32'd400);
        apply("R5 ult", 8'had, 64'h76, 64'h77, 32'h0, 16'h0010, 32'd400);
        apply("R5 ule equal", 8'hbd, 64'h77, 64'h77, 32'h0, 16'h0010, 32'd400);
        apply("R5 ult equal", 8'had, 64'h77, 64'h77, 32'h0, 16'h0010, 32'd400);
        apply("R6 sge equal", 8'h7d, 64'hffff_ffff_ffff_fff0, 64'hffff_ffff_ffff_fff0, 32'h0, 16'h0010, 32'd400);
        apply("R6 slt neg", 8'hcd, 64'hffff_ffff_ffff_fff0, 64'h3, 32'h0, 16'h0010, 32'd400);
        apply("R6 sle imm", 8'hd5, 64'h5, 64'h0, 32'hffff_ffff, 16'h0010, 32'd400);
        apply("R6 sgt equal", 8'h6d, 64'h5, 64'h5, 32'h0, 16'h0010, 32'd400);
        // R7
        apply("R7 bits none", 8'h4d, 64'hf0, 64'h0f, 32'h0, 16'h0020, 32'd500);
        apply("R7 bits hit", 8'h4d, 64'hf0, 64'h10, 32'h0, 16'h0020, 32'd500);
        apply("R7 bits upper wide", 8'h4d, 64'h1_0000_0000, 64'h1_0000_0000, 32'h0, 16'h0020, 32'd500);
        apply("R7 bits upper narrow", 8'h4e, 64'h1_0000_0000, 64'h1_0000_0000, 32'h0, 16'h0020, 32'd500);
        // R10
        apply("R10 call wide", 8'h85, 64'h0, 64'h0, 32'h1, 16'h0020, 32'd600);
        apply("R10 call narrow", 8'h86, 64'h0, 64'h0, 32'h1, 16'h0020, 32'd600);
        apply("R10 exit wide", 8'h95, 64'h0, 64'h0, 32'h0, 16'h0020, 32'd600);
        // R11
        apply("R11 code e", 8'he5, 64'h0, 64'h0, 32'h0, 16'h0020, 32'd700);
        apply("R11 code f", 8'hfe, 64'h0, 64'h0, 32'h0, 16'h0020, 32'd700);
        apply("R11 always narrow", 8'h06, 64'h0, 64'h0, 32'h0, 16'h0020, 32'd700);
        apply("R11 exit narrow", 8'h96, 64'h0, 64'h0, 32'h0, 16'h0020, 32'd700);
        // R9: wrap at both ends
        apply("R9 wrap up", 8'h1d, 64'h1, 64'h2, 32'h0, 16'h0005, 32'hffff_ffff);
        apply("R9 wrap down", 8'h05, 64'h0, 64'h0, 32'h0, 16'hfff0, 32'h0000_0002);
        apply("R9 max fwd", 8'h05, 64'h0, 64'h0, 32'h0, 16'h7fff, 32'h1000);

        // R12: back-to-back random instructions, equality forced sometimes
        for (int i = 0; i < 2000; i++) begin
            logic [7:0]  op;
            logic [63:0] d, s;
            logic [31:0] im;
            op = 8'($urandom);
            if (i % 2 == 0) op[2:0] = (i % 4 == 0) ? 3'd5 : 3'd6;
            d = {$urandom, $urandom};
            s = (i % 5 == 0) ? d : {$urandom, $urandom};
            im = (i % 7 == 0) ? d[31:0] : $urandom;
            apply("R12 random", op, d, s, im, 16'($urandom), $urandom);
        end

        // R1: reset in mid-run clears a taken result
        @(negedge clk);
        op_i = 8'h05; pc_i = 32'h55; rst_n = 1'b0;
        @(negedge clk);
        compare("R1 mid reset", 0, 32'h0, 0, 0, 0);
        rst_n = 1'b1;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule